// File: doc/BRIEF.md
# Address-Space Select and Prefix Unit

This block sits in front of and behind a page-table walker. For every translation request it takes a virtual address, an access type (read, write or instruction fetch), an address-space mode and a translation-enable flag. When translation is on, it picks the root register that the walker should start from. It hands the 4 KB-aligned address to the walker through a start/done handshake, and it adjusts the returned permissions for the mode in use. When translation is off, it uses the aligned address directly as the real address and never starts the walker.

The real address then goes through a two-way prefix swap. The low 8 KB and the 8 KB window at the prefix value trade places, so each one lands where the other was. The resulting absolute address is returned with the final read, write and execute permissions.

As a side effect, the block keeps a storage-key array with one entry per 4 KB page. Each entry holds a referenced bit and a changed bit. The entry for the final address is updated one cycle after the response, and this happens even when the walker reported a fault. A read port exposes the keys.

Top module: `asp_front`

## Requirements
- R1: When `dat_en` is low, the response address is the prefix-swapped form of the virtual address with bits 11..0 cleared. The permissions are all set (`rsp_perm` = 3'b111, where bit 0 is read, bit 1 is write and bit 2 is execute). `walk_start` never rises for such a request.
- R2: When `dat_en` is high, `walk_start` is a one-cycle pulse, and `walk_vaddr` is the 4 KB-aligned virtual address. Mode 0 (primary) presents `cr1` on `walk_root`, and mode 3 (home) presents `cr13`.
- R3: Mode 2 (secondary) with access 2 (instruction fetch) presents `cr1` and clears the read and write permissions. Mode 2 with access 0 (read) or 1 (write) presents `cr7` and clears the execute permission.
- R4: A high `walk_wprot` on the cycle `walk_done` is high clears the write permission.
- R5: The real address r is swapped against the prefix p. If r < 0x2000, the result is r + p. Otherwise, if p <= r < p + 0x2000, the result is r − p. Any other r passes through unchanged.
- R6: The key entry selected by the absolute address divided by 4096 has its referenced bit (bit 0) set when read permission is granted, and its changed bit (bit 1) set when write permission is granted. Key bits are only ever set and accumulate across requests. The key is visible on `key_val` from the cycle after `rsp_valid`.
- R7: `rsp_fault` repeats the `walk_fault` value reported with `walk_done`. The key update of R6 still happens on a faulting translation.
- R8: Mode 1, or access code 3, with `dat_en` high gives a response with `rsp_err` high, `rsp_perm` = 0, `rsp_fault` low and `rsp_addr` = 0. No walk is started and no key changes.
- R9: A synchronous low `rst_n` clears every key and leaves `rsp_valid` and `walk_start` low.
- R10: No key changes when the absolute address is at or above `ram_size`, or when its page index is at or above the key count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_vaddr | input | AW | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode: 0 primary, 1 access-register, 2 secondary, 3 home |
| dat_en | input | 1 | Translation enable |
| cr1 | input | AW | Primary root |
| cr7 | input | AW | Secondary root |
| cr13 | input | AW | Home root |
| prefix | input | AW | Prefix base, 8 KB aligned |
| ram_size | input | AW | Bytes of RAM covered by keys |
| walk_start | output | 1 | Walker start pulse |
| walk_root | output | AW | Selected root for the walker |
| walk_vaddr | output | AW | Aligned virtual address for the walker |
| walk_acc | output | 2 | Access type for the walker |
| walk_done | input | 1 | Walker completion strobe |
| walk_raddr | input | AW | Real address from the walker |
| walk_wprot | input | 1 | Walker found the page write-protected |
| walk_fault | input | 1 | Walker reported a fault |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | AW | Absolute address |
| rsp_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| rsp_fault | output | 1 | Translation fault |
| rsp_err | output | 1 | Unsupported mode or access code |
| key_idx | input | KIW | Key read index |
| key_val | output | 2 | Key read data: bit 0 referenced, bit 1 changed |

## Verification
The assertions assume that a request is only raised while the unit is idle. They also assume the walker answers only after a start pulse, and that `prefix` stays stable and 8 KB aligned while a request is in flight. The stimulus issues one request at a time and waits for its response before the next. Its walker model drives `walk_done` only after it has seen `walk_start`. The prefix is written once, before the traffic starts, to an aligned value.

// File: rtl/asp_pkg.sv
// Shared encodings for the address-space select and prefix unit.
// Assumes a 2-bit mode and access code, and a 3-bit permission vector.
package asp_pkg;
    localparam logic [1:0] MODE_PRI  = 2'd0;
    localparam logic [1:0] MODE_AR   = 2'd1;
    localparam logic [1:0] MODE_SEC  = 2'd2;
    localparam logic [1:0] MODE_HOME = 2'd3;

    localparam logic [1:0] ACC_RD = 2'd0;
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_IF = 2'd2;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_FIN,
        ST_ERR
    } asp_state_t;
endpackage

// File: rtl/asp_root_sel.sv
// Root and permission-mask selection.
// Purely combinational. Maps the address-space mode and access type to a
// walker root and a mask applied to the permissions. An unsupported mode or
// access code drops root_ok.
module asp_root_sel
    import asp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    acc,
    input  logic [AW-1:0] cr1,
    input  logic [AW-1:0] cr7,
    input  logic [AW-1:0] cr13,
    output logic [AW-1:0] root,
    output logic [2:0]    perm_mask,
    output logic          root_ok
);
    logic is_fetch;

    // Decode the access type once for the secondary split.
    always_comb is_fetch = (acc == ACC_IF);

    // Pick the root register and the permission mask for the mode.
    always_comb begin
        root      = '0;
        perm_mask = 3'b111;
        root_ok   = (acc != 2'd3);
        case (mode)
            MODE_PRI:  root = cr1;
            MODE_HOME: root = cr13;
            MODE_SEC: begin
                if (is_fetch) begin
                    root      = cr1;
                    perm_mask = 3'b100;
                end else begin
                    root      = cr7;
                    perm_mask = 3'b011;
                end
            end
            default: root_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/asp_prefix.sv
// Bidirectional low-core prefix swap.
// Combinational. Exchanges the low window with the window at the prefix base.
// Assumes prefix is aligned to LOW_BYTES.
module asp_prefix #(
    parameter int AW        = 32,
    parameter int LOW_BYTES = 'h2000
) (
    input  logic [AW-1:0] raddr,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] abs_addr
);
    localparam logic [AW-1:0] LOW_LIM = AW'(LOW_BYTES);

    logic in_low;
    logic in_pfx;

    // Classify the address against both windows.
    always_comb begin
        in_low = (raddr < LOW_LIM);
        in_pfx = (raddr >= prefix) && ((raddr - prefix) < LOW_LIM);
    end

    // Apply the swap, with the low window taking precedence.
    always_comb begin
        if (in_low)
            abs_addr = raddr + prefix;
        else if (in_pfx)
            abs_addr = raddr - prefix;
        else
            abs_addr = raddr;
    end
endmodule

// File: rtl/asp_keys.sv
// Storage-key array with one 2-bit entry per page: bit 0 referenced,
// bit 1 changed.
// Bits are OR-ed in by a single-cycle read-modify-write when upd_en is high
// and the address is inside RAM and inside the array. Reset clears every key.
module asp_keys #(
    parameter int AW        = 32,
    parameter int NUM_KEYS  = 64,
    parameter int PAGE_BITS = 12,
    localparam int KIW      = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd_en,
    input  logic [AW-1:0]  upd_addr,
    input  logic [AW-1:0]  ram_size,
    input  logic           set_ref,
    input  logic           set_chg,
    input  logic [KIW-1:0] rd_idx,
    output logic [1:0]     rd_key
);
    logic [AW-1:0] page;
    logic          in_range;
    logic [1:0]    key_q [NUM_KEYS];

    // Compute the page index and whether the key exists.
    always_comb begin
        page     = upd_addr >> PAGE_BITS;
        in_range = upd_en && (upd_addr < ram_size) && (page < AW'(NUM_KEYS));
    end

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
        logic hit;

        // Select this entry for update.
        always_comb hit = in_range && (page[KIW-1:0] == KIW'(i));

        // Clear on reset, accumulate bits on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                key_q[i] <= 2'b00;
            else if (hit)
                key_q[i] <= key_q[i] | {set_chg, set_ref};
        end
    end

    // Read port.
    always_comb rd_key = key_q[rd_idx];
endmodule

// File: rtl/asp_front.sv
// Address-space select and prefix unit (top).
// Accepts one request while idle. It either bypasses translation or drives
// the walker with a start pulse and waits for done. The result is masked per
// mode and prefix-swapped, and a response pulse is issued for one cycle. The
// storage key is updated on the cycle after the response.
// Assumes the walker asserts walk_done only after walk_start.
module asp_front
    import asp_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NUM_KEYS  = 64,
    parameter int PAGE_BITS = 12,
    parameter int LOW_BYTES = 'h2000,
    localparam int KIW      = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_vaddr,
    input  logic [1:0]     req_acc,
    input  logic [1:0]     req_mode,
    input  logic           dat_en,
    input  logic [AW-1:0]  cr1,
    input  logic [AW-1:0]  cr7,
    input  logic [AW-1:0]  cr13,
    input  logic [AW-1:0]  prefix,
    input  logic [AW-1:0]  ram_size,
    output logic           walk_start,
    output logic [AW-1:0]  walk_root,
    output logic [AW-1:0]  walk_vaddr,
    output logic [1:0]     walk_acc,
    input  logic           walk_done,
    input  logic [AW-1:0]  walk_raddr,
    input  logic           walk_wprot,
    input  logic           walk_fault,
    output logic           rsp_valid,
    output logic [AW-1:0]  rsp_addr,
    output logic [2:0]     rsp_perm,
    output logic           rsp_fault,
    output logic           rsp_err,
    input  logic [KIW-1:0] key_idx,
    output logic [1:0]     key_val
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));

    asp_state_t    state_q;
    logic [AW-1:0] vaddr_q;
    logic [AW-1:0] raddr_q;
    logic [1:0]    mode_q;
    logic [1:0]    acc_q;
    logic          dat_q;
    logic [2:0]    perm_q;
    logic          fault_q;

    logic [AW-1:0] sel_root;
    logic [2:0]    sel_mask;
    logic          sel_ok;
    logic [AW-1:0] abs_addr;
    logic          fin;

    asp_root_sel #(.AW(AW)) u_sel (
        .mode      (mode_q),
        .acc       (acc_q),
        .cr1       (cr1),
        .cr7       (cr7),
        .cr13      (cr13),
        .root      (sel_root),
        .perm_mask (sel_mask),
        .root_ok   (sel_ok)
    );

    asp_prefix #(.AW(AW), .LOW_BYTES(LOW_BYTES)) u_pfx (
        .raddr    (raddr_q),
        .prefix   (prefix),
        .abs_addr (abs_addr)
    );

    // Response stage is active.
    always_comb fin = (state_q == ST_FIN);

    asp_keys #(.AW(AW), .NUM_KEYS(NUM_KEYS), .PAGE_BITS(PAGE_BITS)) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (fin),
        .upd_addr (abs_addr),
        .ram_size (ram_size),
        .set_ref  (perm_q[PERM_R]),
        .set_chg  (perm_q[PERM_W]),
        .rd_idx   (key_idx),
        .rd_key   (key_val)
    );

    // Request capture and sequencing through walker handshake and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
            raddr_q <= '0;
            mode_q  <= MODE_PRI;
            acc_q   <= ACC_RD;
            dat_q   <= 1'b0;
            perm_q  <= 3'b000;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr & ALIGN_MASK;
                        mode_q  <= req_mode;
                        acc_q   <= req_acc;
                        dat_q   <= dat_en;
                        fault_q <= 1'b0;
                        if (!dat_en) begin
                            raddr_q <= req_vaddr & ALIGN_MASK;
                            perm_q  <= 3'b111;
                            state_q <= ST_FIN;
                        end else begin
                            state_q <= ST_START;
                        end
                    end
                end
                ST_START: begin
                    state_q <= sel_ok ? ST_WAIT : ST_ERR;
                end
                ST_WAIT: begin
                    if (walk_done) begin
                        raddr_q <= walk_raddr;
                        fault_q <= walk_fault;
                        perm_q  <= {1'b1, ~walk_wprot, 1'b1} & sel_mask;
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Walker-side outputs.
    always_comb begin
        walk_start = (state_q == ST_START) && sel_ok;
        walk_root  = sel_root;
        walk_vaddr = vaddr_q;
        walk_acc   = acc_q;
    end

    // Response outputs, zero outside the response cycle.
    always_comb begin
        rsp_valid = fin || (state_q == ST_ERR);
        rsp_err   = (state_q == ST_ERR);
        rsp_addr  = fin ? abs_addr : '0;
        rsp_perm  = fin ? perm_q : 3'b000;
        rsp_fault = fin && fault_q;
    end
endmodule

// File: rtl/asp_front_chk.sv
// Property checker for asp_front, attached by bind.
// Observes the ports and the captured request fields.
module asp_front_chk #(
    parameter int AW        = 32,
    parameter int LOW_BYTES = 'h2000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          walk_start,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic          rsp_fault,
    input logic [2:0]    rsp_perm,
    input logic [AW-1:0] rsp_addr,
    input logic [AW-1:0] prefix,
    input logic [AW-1:0] raddr_q,
    input logic [1:0]    mode_q,
    input logic [1:0]    acc_q,
    input logic          dat_q
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> !walk_start); // R2
    AST_WALK_NEEDS_DAT: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |-> dat_q); // R1
    AST_DATOFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !dat_q) |-> (rsp_perm == 3'b111 && !rsp_err)); // R1
    AST_FETCH_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && dat_q && mode_q == 2'd2 && acc_q == 2'd2)
        |-> (rsp_perm[1:0] == 2'b00)); // R3
    AST_DATA_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && dat_q && mode_q == 2'd2 && acc_q != 2'd2)
        |-> !rsp_perm[2]); // R3
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_perm == 3'b000 && !rsp_fault)); // R8
    AST_LOW_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && raddr_q < AW'(LOW_BYTES))
        |-> (rsp_addr == raddr_q + prefix)); // R5
endmodule

bind asp_front asp_front_chk #(.AW(AW), .LOW_BYTES(LOW_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_start (walk_start),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_fault  (rsp_fault),
    .rsp_perm   (rsp_perm),
    .rsp_addr   (rsp_addr),
    .prefix     (prefix),
    .raddr_q    (raddr_q),
    .mode_q     (mode_q),
    .acc_q      (acc_q),
    .dat_q      (dat_q)
);

// File: tb/asp_front_test.sv
// Self-checking bench for asp_front with a behavioural walker and key model.
module asp_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NK = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_vaddr = '0;
    logic [1:0]    req_acc = '0;
    logic [1:0]    req_mode = '0;
    logic          dat_en = 1'b0;
    logic [AW-1:0] cr1 = 32'h0000_1111;
    logic [AW-1:0] cr7 = 32'h0000_7777;
    logic [AW-1:0] cr13 = 32'h0000_DDDD;
    logic [AW-1:0] prefix = 32'h0001_0000;
    logic [AW-1:0] ram_size = 32'h0003_0000;
    logic          walk_start;
    logic [AW-1:0] walk_root;
    logic [AW-1:0] walk_vaddr;
    logic [1:0]    walk_acc;
    logic          walk_done = 1'b0;
    logic [AW-1:0] walk_raddr = '0;
    logic          walk_wprot = 1'b0;
    logic          walk_fault = 1'b0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic [2:0]    rsp_perm;
    logic          rsp_fault;
    logic          rsp_err;
    logic [5:0]    key_idx = '0;
    logic [1:0]    key_val;

    int checks = 0;
    int errors = 0;
    int mk [NK];

    asp_front uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] swap(logic [AW-1:0] r);
        if (r < 32'h2000) return r + prefix;
        if (r >= prefix && r < prefix + 32'h2000) return r - prefix;
        return r;
    endfunction

    task automatic read_key(int idx, output logic [1:0] v);
        key_idx = 6'(idx);
        #1 v = key_val;
    endtask

    task automatic check_all_keys(string tag);
        logic [1:0] v;
        for (int i = 0; i < NK; i++) begin
            read_key(i, v);
            chk(tag, v, mk[i]);
        end
    endtask

    // One complete request with the walker answering after wdly cycles.
    task automatic do_req(string tag, logic [1:0] mode, logic [1:0] acc,
                          logic dat, logic [AW-1:0] va, logic [AW-1:0] wr,
                          logic wp, logic wf, int wdly);
        logic [AW-1:0] e_root, e_real, e_abs;
        logic [2:0]    e_perm;
        logic          e_err, e_walk, seen, got;
        int            idx;
        logic [1:0]    kv;
        e_err  = dat && (mode == 2'd1 || acc == 2'd3);
        e_walk = dat && !e_err;
        e_root = (mode == 2'd3) ? cr13 :
                 (mode == 2'd2 && acc != 2'd2) ? cr7 : cr1;
        e_real = dat ? wr : (va & 32'hFFFF_F000);
        e_perm = 3'b111;
        if (dat) begin
            if (wp) e_perm[1] = 1'b0;
            if (mode == 2'd2 && acc == 2'd2) e_perm[1:0] = 2'b00;
            if (mode == 2'd2 && acc != 2'd2) e_perm[2] = 1'b0;
        end
        e_abs = swap(e_real);
        @(negedge clk);
        req_valid = 1'b1; req_mode = mode; req_acc = acc;
        dat_en = dat; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 1'b0; got = 1'b0;
        for (int c = 0; c < 60 && !got; c++) begin
            if (rsp_valid) begin
                got = 1'b1;
                chk({tag, " rsp_err"}, rsp_err, e_err);
                if (e_err) begin
                    chk({tag, " R8 perm"}, rsp_perm, 0);
                    chk({tag, " R8 addr"}, rsp_addr, 0);
                    chk({tag, " R8 fault"}, rsp_fault, 0);
                end else begin
                    chk({tag, " addr"}, rsp_addr, e_abs);
                    chk({tag, " perm"}, rsp_perm, e_perm);
                    chk({tag, " R7 fault"}, rsp_fault, dat && wf);
                end
            end else if (walk_start) begin
                seen = 1'b1;
                chk({tag, " R2 root"}, walk_root, e_root);
                chk({tag, " R2 vaddr"}, walk_vaddr, va & 32'hFFFF_F000);
                @(negedge clk);
                chk({tag, " R2 pulse"}, walk_start, 0);
                repeat (wdly) @(negedge clk);
                walk_done = 1'b1; walk_raddr = wr;
                walk_wprot = wp; walk_fault = wf;
                @(negedge clk);
                walk_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk({tag, " response seen"}, got, 1);
        chk({tag, " R1 walk started"}, seen, e_walk);
        if (!e_err && e_abs < ram_size && (e_abs >> 12) < NK) begin
            idx = int'(e_abs >> 12);
            mk[idx] = mk[idx] | {30'd0, e_perm[1], e_perm[0]};
        end
        @(negedge clk);
        if (!e_err && (e_abs >> 12) < NK) begin
            read_key(int'(e_abs >> 12), kv);
            chk({tag, " R6 key"}, kv, mk[int'(e_abs >> 12)]);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NK; i++) mk[i] = 0;
        repeat (3) @(negedge clk);
        chk("R9 reset rsp_valid", rsp_valid, 0);
        chk("R9 reset walk_start", walk_start, 0);
        rst_n = 1'b1;
        check_all_keys("R9 keys after reset");

        do_req("R1 datoff", 2'd0, 2'd0, 1'b0, 32'h0000_3123, '0, 0, 0, 0);
        do_req("R1 R5 datoff low", 2'd0, 2'd0, 1'b0, 32'h0000_0456, '0, 0, 0, 0);
        do_req("R2 R5 primary", 2'd0, 2'd1, 1'b1, 32'h0004_5678,
               32'h0001_1000, 0, 0, 2);
        do_req("R2 R4 home", 2'd3, 2'd0, 1'b1, 32'h0000_9ABC,
               32'h0000_5000, 1, 0, 0);
        do_req("R3 sec fetch", 2'd2, 2'd2, 1'b1, 32'h0000_6FFF,
               32'h0000_6000, 0, 0, 1);
        do_req("R3 sec read", 2'd2, 2'd0, 1'b1, 32'h0000_7001,
               32'h0000_7000, 0, 0, 3);
        do_req("R3 R4 sec write", 2'd2, 2'd1, 1'b1, 32'h0000_8000,
               32'h0000_8000, 1, 0, 0);
        do_req("R7 fault", 2'd0, 2'd0, 1'b1, 32'h0000_9000,
               32'h0000_9000, 0, 1, 1);
        do_req("R8 ar mode", 2'd1, 2'd0, 1'b1, 32'h0000_A000,
               32'h0000_A000, 0, 0, 0);
        do_req("R8 bad acc", 2'd0, 2'd3, 1'b1, 32'h0000_B000,
               32'h0000_B000, 0, 0, 0);
        do_req("R10 below ram", 2'd0, 2'd0, 1'b0, 32'h0002_F000, '0, 0, 0, 0);
        do_req("R10 at ram", 2'd0, 2'd0, 1'b0, 32'h0003_0000, '0, 0, 0, 0);
        do_req("R6 accumulate", 2'd0, 2'd1, 1'b1, 32'h0000_1000,
               32'h0000_5000, 0, 0, 0);
        do_req("R5 pass", 2'd3, 2'd1, 1'b1, 32'h0000_2000,
               32'h0001_2000, 0, 0, 0);
        check_all_keys("R6 R8 R10 keys");

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NK; i++) mk[i] = 0;
        check_all_keys("R9 keys cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule